// File: doc/BRIEF.md
# Multi-line reset controller

This block drives a bank of independent reset outputs toward on-chip subsystems. Software holds or releases each line by writing 32-bit words into an array of line-control registers, and learns whether a change has really reached the subsystem by reading a matching array of read-only completion words. Every line starts held in reset after power-on. After a write releases a line, software polls the completion word until the bit for that line shows the released value.

The completion path does not simply mirror the control bit. Each line's request passes through a two-stage capture chain that only advances on cycles where that line's target-domain enable input is high. This input stands in for the target clock. A line whose target clock is stopped therefore never reports completion. The reported bit also has a per-line sense. Most lines report 0 while held and 1 once released. A parameter mask marks the few lines that report the other way.

The block is a simple single-cycle register slave. Its asynchronous active-low reset is expected to arrive already synchronised to `clk` on release.

Top module: `rstctl_top`

## Requirements
- R1: While `rst_n` is low and after it is released, all control bits are 1. Every `line_rst` output is high, and each completion word reads its polarity-mask word, which is the "held" pattern.
- R2: An aligned write with all four byte enables to byte offset 4*m, for m in 0..3, loads the control word m. Bit n of that word drives `line_rst[32*m+n]`, where 1 holds the line in reset and 0 releases it. The output changes at the clock edge that accepts the write.
- R3: A write to a control word changes only the bytes whose `bus_be` bit is set. `bus_be[k]` covers data bits 8k+7..8k. The other bytes keep their old value.
- R4: An aligned read (`bus_sel`=1, `bus_wr`=0) of control word m returns that word's current contents on `bus_rdata` after the next clock edge. `bus_rdata` holds its value when no read is accepted.
- R5: A read of the completion word at byte offset 0x10+4*m returns one bit per line, from line 32*m up to line 32*m+31. Once settled, a line whose polarity-mask bit is 0 reads 0 while held and 1 while released. A line whose mask bit is 1 reads 1 while held and 0 while released. The default mask has bits 3, 17, 18, 40, 41 and 70 set.
- R6: A line's completion bit follows its control bit only after two clock edges at which its `tgt_en` bit is high. While `tgt_en` for that line is low, its completion bit does not change, however long the gap.
- R7: Writes to the completion-word offsets 0x10 to 0x1C have no effect on any control bit or output.
- R8: An access with `bus_addr[1:0]` not equal to 0 is ignored. A write changes nothing, and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for a write |
| tgt_en | input | NUM_LINES (128) | Per-line target-domain clock enable |
| bus_rdata | output | 32 | Registered read data |
| line_rst | output | NUM_LINES (128) | Active-high reset to each subsystem |

## Verification
A corrupted control bit shows up on `line_rst` at the edge after the write that stored it, and in the next read-back of that control word. A fault in the capture chain or in the polarity mask shows only in the completion words, two enabled edges after a change. Because of this, the bench walks every line through a release, lets it settle, and compares the whole completion word. A chain that advances while its enable is low, or that skips a stage, shows up as a completion bit that changes during a gated interval or after a single enabled edge. The bench reads a gated line repeatedly and then grants the enable one edge at a time to expose both faults.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  localparam int WORD_W     = 32;
  localparam int BYTE_LANES = WORD_W / 8;

  typedef logic [WORD_W-1:0]     word_t;
  typedef logic [BYTE_LANES-1:0] lane_t;

  // Address space half selected by the bit just above the word index.
  typedef enum logic {
    REG_CTRL   = 1'b0,
    REG_STATUS = 1'b1
  } region_e;

  // Replace only the byte lanes whose enable is set.
  function automatic word_t lane_merge(word_t old_w, word_t new_w, lane_t lanes);
    word_t res;
    res = old_w;
    for (int k = 0; k < BYTE_LANES; k++) begin
      if (lanes[k]) res[8*k +: 8] = new_w[8*k +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/rstctl_regs.sv
module rstctl_regs
  import rstctl_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int ADDR_W    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  word_t                       bus_wdata,
  input  lane_t                       bus_be,
  input  logic [NUM_WORDS*WORD_W-1:0] status_vec,
  output logic [NUM_WORDS*WORD_W-1:0] ctrl_vec,
  output word_t                       bus_rdata
);

  localparam int IDX_W = $clog2(NUM_WORDS);

  region_e          acc_region;
  logic [IDX_W-1:0] acc_idx;
  logic             acc_aligned;
  logic             wr_fire;
  logic             rd_fire;

  assign acc_aligned = (bus_addr[1:0] == 2'b00);
  assign acc_region  = region_e'(bus_addr[IDX_W+2]);
  assign acc_idx     = bus_addr[IDX_W+1:2];
  assign wr_fire     = bus_sel & bus_wr & acc_aligned & (acc_region == REG_CTRL);
  assign rd_fire     = bus_sel & ~bus_wr;

  // Control word storage, one register per word.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    word_t word_q;
    word_t word_d;
    logic  hit;

    assign hit = wr_fire & (acc_idx == IDX_W'(w));

    always_comb begin
      word_d = word_q;
      if (hit) word_d = lane_merge(word_q, bus_wdata, bus_be);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '1;
      else        word_q <= word_d;
    end

    assign ctrl_vec[w*WORD_W +: WORD_W] = word_q;
  end

  // Registered read port.
  word_t rdata_q;
  word_t rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_fire) begin
      if (!acc_aligned)                 rdata_d = '0;
      else if (acc_region == REG_CTRL)  rdata_d = ctrl_vec[acc_idx*WORD_W +: WORD_W];
      else                              rdata_d = status_vec[acc_idx*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
  parameter int NUM_LINES = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] tgt_en,
  input  logic [NUM_LINES-1:0] req_in,
  output logic [NUM_LINES-1:0] ack_out
);

  // Two capture stages per line, advanced only when the target enable is high.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic s1_q, s1_d;
    logic s2_q, s2_d;

    always_comb begin
      s1_d = s1_q;
      s2_d = s2_q;
      if (tgt_en[i]) begin
        s1_d = req_in[i];
        s2_d = s1_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= s1_d;
        s2_q <= s2_d;
      end
    end

    assign ack_out[i] = s2_q;
  end

endmodule

// File: rtl/rstctl_status.sv
module rstctl_status #(
  parameter int                   NUM_LINES = 128,
  parameter logic [NUM_LINES-1:0] ACK_POL   = '0
) (
  input  logic [NUM_LINES-1:0] ack_in,
  output logic [NUM_LINES-1:0] status_vec
);

  // A held line reports its mask bit; a released line reports the inverse.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_pol
    if (ACK_POL[i]) begin : g_direct
      assign status_vec[i] = ack_in[i];
    end else begin : g_invert
      assign status_vec[i] = ~ack_in[i];
    end
  end

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int                   NUM_LINES = 128,
  parameter logic [NUM_LINES-1:0] ACK_POL   = 128'h0000_0000_0000_0040_0000_0300_0006_0008,
  localparam int                  NUM_WORDS = NUM_LINES / WORD_W,
  localparam int                  ADDR_W    = $clog2(NUM_WORDS) + 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  input  logic [BYTE_LANES-1:0] bus_be,
  input  logic [NUM_LINES-1:0]  tgt_en,
  output logic [WORD_W-1:0]     bus_rdata,
  output logic [NUM_LINES-1:0]  line_rst
);

  logic [NUM_LINES-1:0] ctrl_vec;
  logic [NUM_LINES-1:0] ack_vec;
  logic [NUM_LINES-1:0] status_vec;

  rstctl_regs #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_be     (bus_be),
    .status_vec (status_vec),
    .ctrl_vec   (ctrl_vec),
    .bus_rdata  (bus_rdata)
  );

  rstctl_sync #(
    .NUM_LINES (NUM_LINES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .tgt_en  (tgt_en),
    .req_in  (ctrl_vec),
    .ack_out (ack_vec)
  );

  rstctl_status #(
    .NUM_LINES (NUM_LINES),
    .ACK_POL   (ACK_POL)
  ) u_status (
    .ack_in     (ack_vec),
    .status_vec (status_vec)
  );

  assign line_rst = ctrl_vec;

endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
  parameter int                   NUM_LINES = 128,
  parameter logic [NUM_LINES-1:0] ACK_POL   = '0,
  localparam int                  WORD_W    = 32,
  localparam int                  NUM_WORDS = NUM_LINES / WORD_W,
  localparam int                  IDX_W     = $clog2(NUM_WORDS),
  localparam int                  ADDR_W    = IDX_W + 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [WORD_W-1:0]    bus_wdata,
  input logic [3:0]           bus_be,
  input logic [WORD_W-1:0]    bus_rdata,
  input logic [NUM_LINES-1:0] tgt_en,
  input logic [NUM_LINES-1:0] line_rst,
  input logic [NUM_LINES-1:0] status_vec
);

  logic             aligned;
  logic             to_status;
  logic [IDX_W-1:0] idx;
  logic             full_wr;
  logic             stat_wr;
  logic             ctrl_rd;
  logic [WORD_W-1:0]    cur_word;
  logic [NUM_LINES-1:0] settle_mask;

  assign aligned     = bus_sel & (bus_addr[1:0] == 2'b00);
  assign to_status   = bus_addr[IDX_W+2];
  assign idx         = bus_addr[IDX_W+1:2];
  assign full_wr     = aligned & bus_wr & ~to_status & (&bus_be);
  assign stat_wr     = bus_sel & bus_wr & to_status;
  assign ctrl_rd     = aligned & ~bus_wr & ~to_status;
  assign cur_word    = line_rst[idx*WORD_W +: WORD_W];

  logic                 fw_q, rd_q;
  logic [IDX_W-1:0]     idx_q;
  logic [WORD_W-1:0]    wd_q, rexp_q;
  logic [NUM_LINES-1:0] en_q, lr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw_q   <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      wd_q   <= '0;
      rexp_q <= '0;
      en_q   <= '0;
      lr_q   <= '1;
    end else begin
      fw_q   <= full_wr;
      rd_q   <= ctrl_rd;
      idx_q  <= idx;
      wd_q   <= bus_wdata;
      rexp_q <= cur_word;
      en_q   <= tgt_en;
      lr_q   <= line_rst;
    end
  end

  assign settle_mask = tgt_en & en_q & ~(line_rst ^ lr_q);

  // R2: a full-width aligned write lands on the outputs at its edge
  a_r2_full_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    fw_q |-> (line_rst[idx_q*WORD_W +: WORD_W] == wd_q));

  // R4: control read returns the word as it stood when the read was taken
  a_r4_read_matches_word: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |-> (bus_rdata == rexp_q));

  // R5: a line stable over two enabled edges reports its polarity-correct value
  a_r5_settled_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status_vec ^ ~($past(line_rst) ^ ACK_POL)) & $past(settle_mask)) == '0));

  // R6: a gated line's completion bit cannot move
  a_r6_hold_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status_vec ^ $past(status_vec)) & ~$past(tgt_en)) == '0));

  // R7: writes into the completion half leave every output untouched
  a_r7_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> $stable(line_rst));

endmodule

bind rstctl_top rstctl_chk #(
  .NUM_LINES (NUM_LINES),
  .ACK_POL   (ACK_POL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_be     (bus_be),
  .bus_rdata  (bus_rdata),
  .tgt_en     (tgt_en),
  .line_rst   (line_rst),
  .status_vec (status_vec)
);

// File: tb/test_rstctl_top.sv
`timescale 1ns/1ps
module test_rstctl_top;

  localparam int          LINES       = 128;
  localparam logic [127:0] POL        = 128'h0000_0000_0000_0040_0000_0300_0006_0008;
  localparam int          GATE_READS  = 20;

  logic         clk;
  logic         rst_n;
  logic         bus_sel;
  logic         bus_wr;
  logic [4:0]   bus_addr;
  logic [31:0]  bus_wdata;
  logic [3:0]   bus_be;
  logic [LINES-1:0] tgt_en;
  logic [31:0]  bus_rdata;
  logic [LINES-1:0] line_rst;

  int unsigned n_tests;
  int unsigned n_fail;
  logic        done;
  logic [31:0] exp_a [4];

  rstctl_top i_rstctl_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .tgt_en    (tgt_en),
    .bus_rdata (bus_rdata),
    .line_rst  (line_rst)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [127:0] exp_lines();
    return {exp_a[3], exp_a[2], exp_a[1], exp_a[0]};
  endfunction

  function automatic logic [31:0] exp_stat(int w);
    return ~(exp_a[w] ^ POL[w*32 +: 32]);
  endfunction

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_lines(string tag);
    n_tests++;
    if (line_rst !== exp_lines()) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, line_rst, exp_lines());
    end
  endtask

  task automatic bus_write(logic [4:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic model_write(int w, logic [31:0] d, logic [3:0] be);
    for (int k = 0; k < 4; k++) if (be[k]) exp_a[w][8*k +: 8] = d[8*k +: 8];
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    n_tests = 0; n_fail = 0; done = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
    tgt_en = '1;
    rst_n = 1'b0;
    for (int w = 0; w < 4; w++) exp_a[w] = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    chk_lines("R1 outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: state after reset
    chk_lines("R1 outputs after reset");
    for (int w = 0; w < 4; w++) begin
      bus_read(5'(4*w), rd);
      chk32("R1 control word", rd, 32'hFFFF_FFFF);
      bus_read(5'(16 + 4*w), rd);
      chk32("R1 completion word", rd, POL[w*32 +: 32]);
    end

    // R2/R5: release and re-hold every line in turn
    for (int i = 0; i < LINES; i++) begin
      int w = i / 32;
      logic [31:0] d = ~(32'h1 << (i % 32));
      bus_write(5'(4*w), d, 4'hF);
      model_write(w, d, 4'hF);
      chk_lines("R2 single release");
      repeat (2) @(negedge clk);
      bus_read(5'(16 + 4*w), rd);
      chk32("R5 single release status", rd, exp_stat(w));
      bus_write(5'(4*w), 32'hFFFF_FFFF, 4'hF);
      model_write(w, 32'hFFFF_FFFF, 4'hF);
      chk_lines("R2 re-hold");
    end

    // R4/R5: mixed patterns, read back and settled status
    for (int w = 0; w < 4; w++) begin
      logic [31:0] d = 32'hA5C3_0F96 ^ (32'(w) * 32'h1357_2468);
      bus_write(5'(4*w), d, 4'hF);
      model_write(w, d, 4'hF);
      bus_read(5'(4*w), rd);
      chk32("R4 readback", rd, exp_a[w]);
    end
    repeat (2) @(negedge clk);
    for (int w = 0; w < 4; w++) begin
      bus_read(5'(16 + 4*w), rd);
      chk32("R5 mixed status", rd, exp_stat(w));
    end

    // R3: every byte-enable combination on word 1
    for (int be = 0; be < 16; be++) begin
      logic [31:0] d = ~exp_a[1];
      bus_write(5'd4, d, 4'(be));
      model_write(1, d, 4'(be));
      chk_lines("R3 byte enables outputs");
      bus_read(5'd4, rd);
      chk32("R3 byte enables readback", rd, exp_a[1]);
    end

    // R7: writes into the completion half
    for (int w = 0; w < 4; w++) begin
      bus_write(5'(16 + 4*w), ~exp_a[w], 4'hF);
      chk_lines("R7 status write ignored");
      bus_read(5'(4*w), rd);
      chk32("R7 control unchanged", rd, exp_a[w]);
    end

    // R8: misaligned accesses
    for (int off = 1; off < 4; off++) begin
      bus_write(5'(off), ~exp_a[0], 4'hF);
      chk_lines("R8 misaligned write ignored");
      bus_read(5'(off), rd);
      chk32("R8 misaligned read", rd, 32'h0);
    end

    // R6: gated target clock
    for (int w = 0; w < 4; w++) begin
      bus_write(5'(4*w), 32'hFFFF_FFFF, 4'hF);
      model_write(w, 32'hFFFF_FFFF, 4'hF);
    end
    repeat (3) @(negedge clk);
    tgt_en[0] = 1'b0;
    tgt_en[3] = 1'b0;
    bus_write(5'd0, 32'hFFFF_FFF6, 4'hF);
    model_write(0, 32'hFFFF_FFF6, 4'hF);
    chk_lines("R2 gated release outputs");
    for (int n = 0; n < GATE_READS; n++) begin
      bus_read(5'd16, rd);
      chk32("R6 gated status held", rd, POL[31:0]);
    end
    @(negedge clk);
    tgt_en[0] = 1'b1; tgt_en[3] = 1'b1;
    @(negedge clk);
    tgt_en[0] = 1'b0; tgt_en[3] = 1'b0;
    bus_read(5'd16, rd);
    chk32("R6 one enabled edge not enough", rd, POL[31:0]);
    @(negedge clk);
    tgt_en[0] = 1'b1; tgt_en[3] = 1'b1;
    bus_read(5'd16, rd);
    chk32("R6 status after second enabled edge", rd, exp_stat(0));
    chk32("R6 expected value", exp_stat(0), 32'h0006_0001);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule